// File: doc/BRIEF.md
# UART Transmit Path with Priority Byte and Flow-Control Status

This block is the sending half of one serial channel. Bytes written through a holding-register port wait in a small queue. A shift stage takes them and sends each one as a frame with one start bit, eight data bits and one stop bit, advancing one bit on every baud tick. The baud tick comes from a generator outside the block.

Two controls sit on top of this path. A freeze input stops new frames from starting. It does not drop anything that is queued, and a frame already on the line runs to its end. The second control is a one-byte priority slot. If the holding register is written while the priority select and the enhanced-function enable are both set, that byte bypasses the queue. It goes out as soon as the frame now on the line has finished, ahead of every queued byte.

A four-bit status word records the last flow-control character seen in each direction. On the transmit side the block compares each byte it starts against two programmable character values, one for resume and one for pause. The receive side is reported to the block by a strobe from the receiver.

Top module: `uart_tx_prio`

## Requirements
- R1: Within a few cycles of reset, with no write, `txd` is 1, `flow_status` is 0 and `fifo_count` is 0.
- R2: Each frame is sent as follows, one bit per baud-tick interval: a 0 start bit, then data bit 0 through data bit 7, then a 1 stop bit. Queued bytes go out in the order they were written.
- R3: While `tx_freeze` is 1 and no frame is on the line, no frame starts and `txd` stays 1. Bytes already queued, and bytes written during the freeze, stay counted in `fifo_count`.
- R4: After `tx_freeze` returns to 0, the queued bytes are sent in their original order.
- R5: If `tx_freeze` rises while a frame is on the line, that frame still completes, including its stop bit.
- R6: A byte held in the priority slot starts at the first frame boundary after it is armed. It goes out ahead of every byte still queued. The slot holds one byte, and a later arming write replaces a byte that is still waiting.
- R7: A write arms the priority slot only when `prio_sel` and `enh_en` are both 1 in the same cycle. Otherwise the byte is queued as normal.
- R8: A write that arms the priority slot does not add the byte to the queue.
- R9: While `tx_freeze` is 1, a write with `prio_sel` and `enh_en` set does not arm the slot and is queued instead.
- R10: When a frame starts whose byte equals `xoff_char`, `flow_status[2]` becomes 1 and `flow_status[3]` becomes 0. For a byte equal to `xon_char` the two bits are the other way round. Any other byte leaves both bits unchanged. If the two character values are equal, the pause meaning wins.
- R11: A pulse on `rx_flow_evt` sets `flow_status[1:0]` to 2'b10 when `rx_flow_xon` is 1, and to 2'b01 when it is 0.
- R12: A write to a full queue is dropped, and `fifo_full` is 1 while the queue holds DEPTH bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hr_wr | input | 1 | Holding-register write strobe |
| hr_data | input | DATA_W | Byte written |
| tx_freeze | input | 1 | Transmit disable |
| prio_sel | input | 1 | Selects the priority slot for the next write |
| enh_en | input | 1 | Enhanced-function enable that arming requires |
| xon_char | input | DATA_W | Resume character value |
| xoff_char | input | DATA_W | Pause character value |
| rx_flow_evt | input | 1 | Receiver saw a flow-control character |
| rx_flow_xon | input | 1 | That character was resume (1) or pause (0) |
| baud_tick | input | 1 | One-cycle bit-period strobe |
| txd | output | 1 | Serial output, idle high |
| fifo_count | output | $clog2(DEPTH+1) | Bytes queued |
| fifo_full | output | 1 | Queue full |
| flow_status | output | 4 | [0] rx pause, [1] rx resume, [2] tx pause, [3] tx resume |

## Verification
The bench builds the block with DATA_W=8 and DEPTH=4, and a baud tick comes every fourth clock. The shallow queue makes the full and drop cases reachable with five writes. The short bit period keeps each frame to 40 cycles, so a run can cover freezing in the middle of a frame, arming the priority slot while a frame is on the line, and a full drain of the queue after a freeze.

// File: rtl/uart_tx_prio_pkg.sv
package uart_tx_prio_pkg;
  localparam int unsigned ST_RX_XOFF = 0;
  localparam int unsigned ST_RX_XON  = 1;
  localparam int unsigned ST_TX_XOFF = 2;
  localparam int unsigned ST_TX_XON  = 3;
  localparam int unsigned ST_W       = 4;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       pop,
  output logic [DATA_W-1:0]          pop_data,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    push_ok  = push && (cnt_q != CNT_W'(DEPTH));
    pop_ok   = pop && (cnt_q != '0);
    wr_ptr_d = push_ok ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop_ok ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok && !pop_ok) cnt_d = cnt_q + CNT_W'(1);
    if (pop_ok && !push_ok) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign pop_data = mem[rd_ptr_q];
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign count    = cnt_q;

  // R12: a write while full must not raise the level
  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> (count == $past(count)));
  assert_level_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_freeze,
  input  logic              imm_valid,
  input  logic [DATA_W-1:0] imm_data,
  input  logic              fifo_valid,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              take_imm,
  output logic              take_fifo,
  output logic              load_valid,
  output logic [DATA_W-1:0] load_data,
  output logic              txd
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DATA_W:0]  sh_q, sh_d;
  logic             txd_q, txd_d;
  logic             boundary;

  always_comb begin
    boundary   = baud_tick && (cnt_q == '0);
    take_imm   = boundary && !tx_freeze && imm_valid;
    take_fifo  = boundary && !tx_freeze && !imm_valid && fifo_valid;
    load_valid = take_imm || take_fifo;
    load_data  = take_imm ? imm_data : fifo_data;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    txd_d = txd_q;
    if (load_valid) begin
      txd_d = 1'b0;
      sh_d  = {1'b1, load_data};
      cnt_d = CNT_W'(FRAME_BITS - 1);
    end else if (baud_tick && (cnt_q != '0)) begin
      txd_d = sh_q[0];
      sh_d  = {1'b1, sh_q[DATA_W:1]};
      cnt_d = cnt_q - CNT_W'(1);
    end else if (boundary) begin
      txd_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '1;
      txd_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      txd_q <= txd_d;
    end
  end

  assign txd = txd_q;

  // R1: between frames the line is high
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> txd);
  // R3: frozen at a boundary, nothing starts
  assert_hold_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && (cnt_q == '0) && tx_freeze) |=> ((cnt_q == '0) && txd));
  // R5: a frame on the line keeps counting down regardless of freeze
  assert_frame_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/uart_flow_status.sv
module uart_flow_status
  import uart_tx_prio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_load_valid,
  input  logic [DATA_W-1:0] tx_load_data,
  input  logic [DATA_W-1:0] xon_char,
  input  logic [DATA_W-1:0] xoff_char,
  input  logic              rx_evt,
  input  logic              rx_is_xon,
  output logic [ST_W-1:0]   status
);
  logic [ST_W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (rx_evt) begin
      st_d[ST_RX_XOFF] = !rx_is_xon;
      st_d[ST_RX_XON]  = rx_is_xon;
    end
    if (tx_load_valid) begin
      if (tx_load_data == xoff_char) begin
        st_d[ST_TX_XOFF] = 1'b1;
        st_d[ST_TX_XON]  = 1'b0;
      end else if (tx_load_data == xon_char) begin
        st_d[ST_TX_XOFF] = 1'b0;
        st_d[ST_TX_XON]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign status = st_q;

  assert_tx_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status[ST_TX_XON:ST_TX_XOFF]));
  assert_tx_pause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load_valid && (tx_load_data == xoff_char)) |=> status[ST_TX_XOFF]);
  assert_rx_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status[ST_RX_XON:ST_RX_XOFF]));
endmodule

// File: rtl/uart_tx_prio.sv
module uart_tx_prio
  import uart_tx_prio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hr_wr,
  input  logic [DATA_W-1:0]          hr_data,
  input  logic                       tx_freeze,
  input  logic                       prio_sel,
  input  logic                       enh_en,
  input  logic [DATA_W-1:0]          xon_char,
  input  logic [DATA_W-1:0]          xoff_char,
  input  logic                       rx_flow_evt,
  input  logic                       rx_flow_xon,
  input  logic                       baud_tick,
  output logic                       txd,
  output logic [$clog2(DEPTH+1)-1:0] fifo_count,
  output logic                       fifo_full,
  output logic [ST_W-1:0]            flow_status
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              arm_wr, push;
  logic              imm_valid_q, imm_valid_d;
  logic [DATA_W-1:0] imm_data_q, imm_data_d;
  logic              take_imm, take_fifo, load_valid;
  logic [DATA_W-1:0] load_data, fifo_head;
  logic              fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  always_comb begin
    arm_wr      = hr_wr && prio_sel && enh_en && !tx_freeze;
    push        = hr_wr && !arm_wr;
    imm_valid_d = imm_valid_q;
    imm_data_d  = imm_data_q;
    if (take_imm) imm_valid_d = 1'b0;
    if (arm_wr) begin
      imm_valid_d = 1'b1;
      imm_data_d  = hr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      imm_valid_q <= 1'b0;
      imm_data_q  <= '0;
    end else begin
      imm_valid_q <= imm_valid_d;
      imm_data_q  <= imm_data_d;
    end
  end

  uart_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n_int), .push(push), .push_data(hr_data),
    .pop(take_fifo), .pop_data(fifo_head), .empty(fifo_empty),
    .full(fifo_full), .count(fifo_count)
  );

  uart_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n_int), .baud_tick(baud_tick), .tx_freeze(tx_freeze),
    .imm_valid(imm_valid_q), .imm_data(imm_data_q),
    .fifo_valid(!fifo_empty), .fifo_data(fifo_head),
    .take_imm(take_imm), .take_fifo(take_fifo),
    .load_valid(load_valid), .load_data(load_data), .txd(txd)
  );

  uart_flow_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n_int), .tx_load_valid(load_valid),
    .tx_load_data(load_data), .xon_char(xon_char), .xoff_char(xoff_char),
    .rx_evt(rx_flow_evt), .rx_is_xon(rx_flow_xon), .status(flow_status)
  );

  // R8: an arming write leaves the queue level alone
  assert_arm_no_push_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (arm_wr && !take_fifo) |=> (fifo_count == $past(fifo_count)));
  // R6: the queue never wins while the priority slot is full
  assert_prio_first_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    take_fifo |-> !imm_valid_q);
  // R9: no arming while frozen
  assert_no_arm_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (tx_freeze && !imm_valid_q) |=> !imm_valid_q);
endmodule

// File: tb/uart_tx_prio_bench.sv
module uart_tx_prio_bench;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam logic [7:0] XON  = 8'h11;
  localparam logic [7:0] XOFF = 8'h13;
  // {byte, expected flow_status[3:2]} ; [3]=tx resume, [2]=tx pause
  localparam logic [9:0] VEC [0:5] = '{
    {8'h13, 2'b01}, {8'h55, 2'b01}, {8'h11, 2'b10},
    {8'h00, 2'b10}, {8'hFF, 2'b10}, {8'h13, 2'b01}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hr_wr = 1'b0;
  logic [7:0] hr_data = '0;
  logic tx_freeze = 1'b0, prio_sel = 1'b0, enh_en = 1'b0;
  logic [7:0] xon_char = XON, xoff_char = XOFF;
  logic rx_flow_evt = 1'b0, rx_flow_xon = 1'b0;
  logic baud_tick = 1'b0;
  logic txd, fifo_full;
  logic [$clog2(DEPTH+1)-1:0] fifo_count;
  logic [3:0] flow_status;

  int checks = 0, failures = 0;
  logic [7:0] rx_buf [0:63];
  int rx_n = 0, frame_err = 0;

  always #5 clk = ~clk;

  uart_tx_prio #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_uart_tx_prio (
    .clk(clk), .rst_n(rst_n), .hr_wr(hr_wr), .hr_data(hr_data),
    .tx_freeze(tx_freeze), .prio_sel(prio_sel), .enh_en(enh_en),
    .xon_char(xon_char), .xoff_char(xoff_char), .rx_flow_evt(rx_flow_evt),
    .rx_flow_xon(rx_flow_xon), .baud_tick(baud_tick), .txd(txd),
    .fifo_count(fifo_count), .fifo_full(fifo_full), .flow_status(flow_status)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  // line monitor: one bit per tick, sampled after the edge
  initial begin
    int bitn;
    logic t;
    logic [7:0] sh;
    bitn = -1;
    sh = '0;
    forever begin
      @(posedge clk);
      t = baud_tick;
      #2;
      if (t && rst_n) begin
        if (bitn < 0) begin
          if (txd == 1'b0) bitn = 0;
        end else if (bitn < 8) begin
          sh[bitn] = txd;
          bitn++;
        end else begin
          if (txd !== 1'b1) frame_err++;
          rx_buf[rx_n] = sh;
          rx_n++;
          bitn = -1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic prio);
    @(negedge clk);
    hr_wr = 1'b1; hr_data = d; prio_sel = prio;
    @(negedge clk);
    hr_wr = 1'b0; prio_sel = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    for (int i = 0; i < 3000 && rx_n < n; i++) @(negedge clk);
  endtask

  task automatic wait_popped();
    for (int i = 0; i < 200 && fifo_count != 0; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(flow_status == 4'h0, "R1 status", flow_status, 0);
    check(fifo_count == 0, "R1 count", fifo_count, 0);

    // R2, R10: table of bytes and expected transmit status
    for (int v = 0; v < 6; v++) begin
      base = rx_n;
      wr(VEC[v][9:2], 1'b0);
      wait_rx(base + 1);
      check(rx_buf[base] == VEC[v][9:2], "R2 frame data", rx_buf[base], VEC[v][9:2]);
      check(flow_status[3:2] == VEC[v][1:0], "R10 tx status", flow_status[3:2], VEC[v][1:0]);
    end
    check(frame_err == 0, "R2 stop bit", frame_err, 0);

    // R3 / R4: freeze while idle, then resume in order
    base = rx_n;
    @(negedge clk) tx_freeze = 1'b1;
    wr(8'h21, 1'b0); wr(8'h42, 1'b0); wr(8'h84, 1'b0);
    repeat (120) @(negedge clk);
    check(rx_n == base, "R3 nothing sent", rx_n, base);
    check(fifo_count == 3, "R3 kept queued", fifo_count, 3);
    check(txd == 1'b1, "R3 line idle", txd, 1);
    @(negedge clk) tx_freeze = 1'b0;
    wait_rx(base + 3);
    check(rx_buf[base] == 8'h21, "R4 order 0", rx_buf[base], 8'h21);
    check(rx_buf[base+1] == 8'h42, "R4 order 1", rx_buf[base+1], 8'h42);
    check(rx_buf[base+2] == 8'h84, "R4 order 2", rx_buf[base+2], 8'h84);

    // R12: overfill while frozen
    base = rx_n;
    @(negedge clk) tx_freeze = 1'b1;
    for (int k = 1; k <= 5; k++) wr(8'(k), 1'b0);
    check(fifo_count == 4, "R12 level", fifo_count, 4);
    check(fifo_full == 1'b1, "R12 full", fifo_full, 1);
    @(negedge clk) tx_freeze = 1'b0;
    wait_rx(base + 4);
    repeat (120) @(negedge clk);
    check(rx_n == base + 4, "R12 dropped byte", rx_n - base, 4);
    check(rx_buf[base+3] == 8'h04, "R12 last kept", rx_buf[base+3], 8'h04);

    // R5: freeze in the middle of a frame
    base = rx_n;
    wr(8'h96, 1'b0);
    for (int i = 0; i < 200 && txd != 1'b0; i++) @(negedge clk);
    tx_freeze = 1'b1;
    wr(8'h69, 1'b0);
    repeat (160) @(negedge clk);
    check(rx_n == base + 1, "R5 frame completed", rx_n - base, 1);
    check(rx_buf[base] == 8'h96, "R5 frame data", rx_buf[base], 8'h96);
    check(fifo_count == 1, "R5 next held", fifo_count, 1);
    @(negedge clk) tx_freeze = 1'b0;
    wait_rx(base + 2);
    check(rx_buf[base+1] == 8'h69, "R5 resumed", rx_buf[base+1], 8'h69);

    // R6 / R8: priority byte jumps the queue after the current frame
    base = rx_n;
    wr(8'hA1, 1'b0);
    wait_popped();
    wr(8'hB2, 1'b0); wr(8'hC3, 1'b0);
    @(negedge clk) enh_en = 1'b1;
    wr(8'hE7, 1'b1);
    check(fifo_count == 2, "R8 arm not queued", fifo_count, 2);
    @(negedge clk) enh_en = 1'b0;
    wait_rx(base + 4);
    check(rx_buf[base] == 8'hA1, "R6 current first", rx_buf[base], 8'hA1);
    check(rx_buf[base+1] == 8'hE7, "R6 priority next", rx_buf[base+1], 8'hE7);
    check(rx_buf[base+2] == 8'hB2, "R6 queue after", rx_buf[base+2], 8'hB2);
    check(rx_buf[base+3] == 8'hC3, "R6 queue tail", rx_buf[base+3], 8'hC3);

    // R7: select without enable queues the byte
    base = rx_n;
    wr(8'h3C, 1'b0);
    wait_popped();
    wr(8'h5A, 1'b1); wr(8'h7E, 1'b0);
    check(fifo_count == 2, "R7 queued without enable", fifo_count, 2);
    wait_rx(base + 3);
    check(rx_buf[base+1] == 8'h5A, "R7 order kept", rx_buf[base+1], 8'h5A);

    // R9: arming ignored while frozen
    base = rx_n;
    @(negedge clk) begin tx_freeze = 1'b1; enh_en = 1'b1; end
    wr(8'hD4, 1'b1);
    check(fifo_count == 1, "R9 queued while frozen", fifo_count, 1);
    @(negedge clk) begin tx_freeze = 1'b0; enh_en = 1'b0; end
    wait_rx(base + 1);
    check(rx_buf[base] == 8'hD4, "R9 sent from queue", rx_buf[base], 8'hD4);

    // R10: equal character values, pause wins
    base = rx_n;
    @(negedge clk) begin xon_char = 8'h77; xoff_char = 8'h77; end
    wr(8'h11, 1'b0);
    wait_rx(base + 1);
    check(flow_status[3:2] == 2'b01, "R10 unmatched keeps", flow_status[3:2], 2'b01);
    wr(8'h77, 1'b0);
    wait_rx(base + 2);
    check(flow_status[3:2] == 2'b01, "R10 equal values", flow_status[3:2], 2'b01);

    // R11: receive-side indications
    @(negedge clk) begin rx_flow_evt = 1'b1; rx_flow_xon = 1'b0; end
    @(negedge clk) rx_flow_evt = 1'b0;
    check(flow_status[1:0] == 2'b01, "R11 rx pause", flow_status[1:0], 2'b01);
    @(negedge clk) begin rx_flow_evt = 1'b1; rx_flow_xon = 1'b1; end
    @(negedge clk) rx_flow_evt = 1'b0;
    check(flow_status[1:0] == 2'b10, "R11 rx resume", flow_status[1:0], 2'b10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule